// File: doc/BRIEF.md
# Serial Flash Presence Probe

This block is a small SPI master that answers one question: is a serial flash device attached and alive? When it sees a start pulse it runs a fixed three-stage command sequence on the bus. The sequence is built to give a reliable answer whatever state the flash was left in. First it polls the status register until the device is not busy. Next it sends a mode-reset frame, which pulls the device out of any dual-I/O read mode. Last it sends a wake-from-power-down command and reads back the identification byte that the device returns at the end of that command.

Presence is decided from that final byte alone. A bus on which MISO never rises, for example because the flash clock pin is shared with a debug port and is held, ends the busy poll at once. It then returns an identification byte of zero, so the block reports that no device is present. A device that stays busy is given a bounded number of polls. After that the probe stops and reports a timeout.

The probe is meant for boot or self-test logic. That logic pulses `start`, waits for `done`, and then reads `present`, `timeout` and `dev_id`. These three results hold steady until the next probe.

Top module: `flash_probe`

## Requirements
- R1: After reset and until a start pulse is accepted, `cs_n` is 1, `sclk` is 0, `done` is 0, and `present`, `timeout` and `dev_id` are all 0.
- R2: Bytes are transferred in SPI mode 0 with the most significant bit first. MOSI changes while `sclk` is low, MISO is sampled on the rising edge, one SCLK period lasts CLK_DIV clock cycles, and `sclk` is 0 whenever `cs_n` is 1.
- R3: The sequence opens with a status frame of two bytes, 0x05 followed by 0x00. This frame is repeated, each time under its own chip-select assertion, for as long as bit 0 (busy) of the byte received during its second byte reads 1.
- R4: Once a status byte shows bit 0 clear, exactly two more frames follow. The first is 0xFF, 0xFF (two bytes). The second is 0xAB followed by four 0x00 bytes (five bytes). Each frame has its own chip-select assertion.
- R5: Between two consecutive frames, `cs_n` stays high for at least CS_GAP_SCLK × CLK_DIV clock cycles.
- R6: `dev_id` takes the byte received during the fifth byte of the wake frame. `present` is 1 only when that byte equals ID_CODE (default 0x12).
- R7: When MISO is always 0, the probe sends exactly one status frame, then the mode-reset and wake frames, and ends with `dev_id` = 0, `present` = 0 and `timeout` = 0.
- R8: When POLL_LIMIT status frames in a row all report busy, the probe sends no further frames and ends with `timeout` = 1, `present` = 0 and `dev_id` = 0. If busy clears on the POLL_LIMIT-th frame, the probe completes normally.
- R9: `done` is high for exactly one cycle at the end of every probe. `present`, `timeout` and `dev_id` keep their values until the next accepted start, which clears all three on the following cycle.
- R10: A start pulse that arrives while a probe is running has no effect. Neither the frame sequence nor the number of `done` pulses changes.
- R11: `probe_busy` is 1 from the cycle after an accepted start until the cycle in which `done` is 1, when it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a probe |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | SPI data to the flash |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | SPI data from the flash |
| probe_busy | output | 1 | A probe is in progress |
| done | output | 1 | One-cycle pulse when the probe ends |
| present | output | 1 | Matching identification byte was received |
| timeout | output | 1 | Busy poll reached its limit |
| dev_id | output | 8 | Identification byte captured by the last probe |

## Verification
The hardest case to reach from the ports is the edge of the poll limit. Busy must stay set for exactly POLL_LIMIT−1 frames in one run and for POLL_LIMIT frames in another. One extra or one missing iteration separates a normal finish from an abort. The bench uses a behavioral flash model with a busy countdown that drops by one at the end of every status frame. It pairs this with a small POLL_LIMIT, so the model walks the probe to both sides of that boundary. It also forces MISO stuck high and stuck low to reach the abort path and the all-zero path.

// File: rtl/flash_probe_pkg.sv
// Package: shared types and frame contents for the flash presence probe.
// Assumes the frame contents below are the only bytes the probe ever sends.
package flash_probe_pkg;

    // Command frames the sequencer can issue; FRM_NONE marks "sequence finished".
    typedef enum logic [1:0] {
        FRM_STATUS  = 2'd0,
        FRM_MODERST = 2'd1,
        FRM_WAKE    = 2'd2,
        FRM_NONE    = 2'd3
    } frame_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_SELECT = 2'd1,
        PS_SHIFT  = 2'd2,
        PS_GAP    = 2'd3
    } pstate_e;

    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_MODERST = 8'hFF;
    localparam logic [7:0] OP_WAKE    = 8'hAB;
    localparam logic [7:0] FILL_ZERO  = 8'h00;
    localparam int         BUSY_BIT   = 0;

    // Number of bytes in a frame.
    function automatic logic [2:0] frame_bytes(frame_e f);
        case (f)
            FRM_STATUS:  return 3'd2;
            FRM_MODERST: return 3'd2;
            FRM_WAKE:    return 3'd5;
            default:     return 3'd1;
        endcase
    endfunction

    // Byte sent at position idx of a frame.
    function automatic logic [7:0] frame_byte(frame_e f, logic [2:0] idx);
        case (f)
            FRM_STATUS:  return (idx == 3'd0) ? OP_STATUS : FILL_ZERO;
            FRM_MODERST: return OP_MODERST;
            FRM_WAKE:    return (idx == 3'd0) ? OP_WAKE : FILL_ZERO;
            default:     return FILL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/fp_byte_engine.sv
// Module: fp_byte_engine
// Shifts one byte in SPI mode 0, most significant bit first, with SCLK derived
// from clk by an even divider of CLK_DIV (half period = CLK_DIV/2 cycles).
// Assumes go arrives only while idle and chip select is already asserted.
// byte_done pulses on the last falling SCLK edge; rx_byte is valid then.
module fp_byte_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int HALF = (CLK_DIV / 2 < 1) ? 1 : CLK_DIV / 2;
    localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;

    logic           active;
    logic [HCW-1:0] hcnt;
    logic [2:0]     bit_idx;
    logic [7:0]     tx_sh;
    logic [7:0]     rx_sh;

    assign rx_byte = rx_sh;

    // Divider, edge generation, transmit shift and receive sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            hcnt      <= '0;
            bit_idx   <= 3'd0;
            tx_sh     <= 8'h00;
            rx_sh     <= 8'h00;
            sclk      <= 1'b0;
            mosi      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go && !active) begin
                active  <= 1'b1;
                hcnt    <= '0;
                bit_idx <= 3'd0;
                tx_sh   <= tx_byte;
                mosi    <= tx_byte[7];
                sclk    <= 1'b0;
            end else if (active) begin
                if (hcnt == HCW'(HALF - 1)) begin
                    hcnt <= '0;
                    if (!sclk) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                            mosi      <= 1'b0;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            mosi    <= tx_sh[6];
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fp_sequencer.sv
// Module: fp_sequencer
// Runs the probe: status polling, mode reset, wake with ID read; frames
// chip select, enforces the inter-frame gap and publishes the result.
// Assumes the byte engine accepts xfer_go one cycle after byte_done.
module fp_sequencer
    import flash_probe_pkg::*;
#(
    parameter int         POLL_LIMIT = 1024,
    parameter int         GAP_CYC    = 8,
    parameter logic [7:0] ID_CODE    = 8'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    output logic       xfer_go,
    output logic [7:0] tx_byte,
    output logic       cs_n,
    output logic       probe_busy,
    output logic       done,
    output logic       present,
    output logic       timeout,
    output logic [7:0] dev_id
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam int GCW = $clog2(GAP_CYC + 1);

    pstate_e        state;
    frame_e         cur_frame;
    frame_e         nxt_frame;
    logic [2:0]     byte_idx;
    logic [PCW-1:0] poll_cnt;
    logic [GCW-1:0] gap_cnt;
    logic [7:0]     id_cap;
    logic           abort;
    logic           last_byte;

    // Current byte closes its frame.
    always_comb last_byte = (byte_idx == frame_bytes(cur_frame) - 3'd1);

    // Probe state machine, frame decisions and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PS_IDLE;
            cur_frame  <= FRM_STATUS;
            nxt_frame  <= FRM_NONE;
            byte_idx   <= 3'd0;
            poll_cnt   <= '0;
            gap_cnt    <= '0;
            id_cap     <= 8'h00;
            abort      <= 1'b0;
            xfer_go    <= 1'b0;
            tx_byte    <= 8'h00;
            cs_n       <= 1'b1;
            probe_busy <= 1'b0;
            done       <= 1'b0;
            present    <= 1'b0;
            timeout    <= 1'b0;
            dev_id     <= 8'h00;
        end else begin
            xfer_go <= 1'b0;
            done    <= 1'b0;
            case (state)
                PS_IDLE: begin
                    if (start) begin
                        probe_busy <= 1'b1;
                        present    <= 1'b0;
                        timeout    <= 1'b0;
                        dev_id     <= 8'h00;
                        id_cap     <= 8'h00;
                        abort      <= 1'b0;
                        poll_cnt   <= '0;
                        cur_frame  <= FRM_STATUS;
                        state      <= PS_SELECT;
                    end
                end
                PS_SELECT: begin
                    cs_n     <= 1'b0;
                    byte_idx <= 3'd0;
                    tx_byte  <= frame_byte(cur_frame, 3'd0);
                    xfer_go  <= 1'b1;
                    state    <= PS_SHIFT;
                end
                PS_SHIFT: begin
                    if (byte_done) begin
                        if (last_byte) begin
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                            state   <= PS_GAP;
                            case (cur_frame)
                                FRM_STATUS: begin
                                    if (!rx_byte[BUSY_BIT]) begin
                                        nxt_frame <= FRM_MODERST;
                                    end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                                        nxt_frame <= FRM_NONE;
                                        abort     <= 1'b1;
                                    end else begin
                                        poll_cnt  <= poll_cnt + 1'b1;
                                        nxt_frame <= FRM_STATUS;
                                    end
                                end
                                FRM_MODERST: nxt_frame <= FRM_WAKE;
                                FRM_WAKE: begin
                                    id_cap    <= rx_byte;
                                    nxt_frame <= FRM_NONE;
                                end
                                default: nxt_frame <= FRM_NONE;
                            endcase
                        end else begin
                            byte_idx <= byte_idx + 3'd1;
                            tx_byte  <= frame_byte(cur_frame, byte_idx + 3'd1);
                            xfer_go  <= 1'b1;
                        end
                    end
                end
                PS_GAP: begin
                    if (gap_cnt == GCW'(GAP_CYC - 1)) begin
                        if (nxt_frame == FRM_NONE) begin
                            state      <= PS_IDLE;
                            probe_busy <= 1'b0;
                            done       <= 1'b1;
                            timeout    <= abort;
                            present    <= !abort && (id_cap == ID_CODE);
                            dev_id     <= abort ? 8'h00 : id_cap;
                        end else begin
                            cur_frame <= nxt_frame;
                            state     <= PS_SELECT;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_probe.sv
// Module: flash_probe (top)
// SPI master that probes for an attached serial flash on a start pulse.
// Assumes CLK_DIV is even and at least 2, CS_GAP_SCLK is at least 2 and
// POLL_LIMIT is at least 1.
module flash_probe #(
    parameter int         CLK_DIV     = 4,
    parameter int         CS_GAP_SCLK = 2,
    parameter int         POLL_LIMIT  = 1024,
    parameter logic [7:0] ID_CODE     = 8'h12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    input  logic       miso,
    output logic       probe_busy,
    output logic       done,
    output logic       present,
    output logic       timeout,
    output logic [7:0] dev_id
);
    localparam int GAP_CYC = CS_GAP_SCLK * CLK_DIV;

    logic       xfer_go;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       byte_done;

    fp_byte_engine #(
        .CLK_DIV (CLK_DIV)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (xfer_go),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    fp_sequencer #(
        .POLL_LIMIT (POLL_LIMIT),
        .GAP_CYC    (GAP_CYC),
        .ID_CODE    (ID_CODE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .xfer_go    (xfer_go),
        .tx_byte    (tx_byte),
        .cs_n       (cs_n),
        .probe_busy (probe_busy),
        .done       (done),
        .present    (present),
        .timeout    (timeout),
        .dev_id     (dev_id)
    );

endmodule

// File: rtl/flash_probe_sva.sv
// Module: flash_probe_sva
// Protocol and result checks for flash_probe, attached by bind below.
module flash_probe_sva #(
    parameter logic [7:0] ID_CODE = 8'h12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       sclk,
    input logic       cs_n,
    input logic       probe_busy,
    input logic       done,
    input logic       present,
    input logic       timeout,
    input logic [7:0] dev_id
);
    a_r2_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({present, timeout, dev_id}) |-> (done || $past(start)));

    a_r11_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_busy |-> cs_n);

    a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!probe_busy && $past(probe_busy)));

    a_r10_busy_ends_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(probe_busy) |-> done);

    a_r6_present_matches_id: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> (dev_id == ID_CODE));

    a_r8_timeout_excludes_present: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!present && dev_id == 8'h00));

endmodule

bind flash_probe flash_probe_sva #(.ID_CODE(ID_CODE)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .probe_busy (probe_busy),
    .done       (done),
    .present    (present),
    .timeout    (timeout),
    .dev_id     (dev_id)
);

// File: tb/flash_probe_tb.sv
`timescale 1ns/1ps
// Directed bench for flash_probe with a behavioral SPI flash model.
module flash_probe_tb;
    localparam int         CLK_DIV     = 4;
    localparam int         CS_GAP_SCLK = 2;
    localparam int         POLL_LIMIT  = 4;
    localparam logic [7:0] ID_CODE     = 8'h12;
    localparam int         GAP_CYC     = CS_GAP_SCLK * CLK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sclk, mosi, cs_n, miso;
    logic       probe_busy, done, present, timeout;
    logic [7:0] dev_id;

    always #2.5 clk = ~clk;

    flash_probe #(
        .CLK_DIV(CLK_DIV), .CS_GAP_SCLK(CS_GAP_SCLK),
        .POLL_LIMIT(POLL_LIMIT), .ID_CODE(ID_CODE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .miso(miso), .probe_busy(probe_busy), .done(done),
        .present(present), .timeout(timeout), .dev_id(dev_id)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    int         miso_mode = 1;   // 0 model, 1 stuck low, 2 stuck high
    int         busy_left = 0;
    logic [7:0] model_id = 8'h12;
    logic       miso_r = 1'b0;
    int         bitn = 0;
    int         bidx = 0;
    logic [7:0] cmd = 8'h00;
    logic [7:0] inb = 8'h00;
    logic [7:0] frm_cmd [64];
    int         frm_len [64];
    int         nfrm = 0;
    int         byte_err = 0;

    assign miso = (miso_mode == 2) ? 1'b1 : (miso_mode == 1) ? 1'b0 : miso_r;

    function automatic logic [7:0] resp(input int idx);
        if (idx == 0) return 8'h00;
        if (cmd == 8'h05) return (busy_left > 0) ? 8'h01 : 8'h00;
        if (cmd == 8'hAB) begin
            if (idx == 4) return model_id;
            if (idx == 3) return 8'h5A;
        end
        return 8'h00;
    endfunction

    function automatic bit payload_ok(input logic [7:0] c, input logic [7:0] b);
        if (c == 8'h05 || c == 8'hAB) return b == 8'h00;
        if (c == 8'hFF) return b == 8'hFF;
        return 1'b0;
    endfunction

    always @(negedge cs_n) begin
        bitn = 0; bidx = 0; inb = 8'h00; cmd = 8'h00; miso_r = 1'b0;
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        inb = {inb[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
            if (bidx == 0) begin
                cmd = inb;
                if (!(inb == 8'h05 || inb == 8'hFF || inb == 8'hAB)) byte_err++;
            end else if (!payload_ok(cmd, inb)) byte_err++;
            bidx++;
            bitn = 0;
        end
    end

    always @(negedge sclk) if (cs_n === 1'b0) begin : drive_blk
        logic [7:0] r;
        r = resp(bidx);
        miso_r = r[7 - bitn];
    end

    always @(posedge cs_n) begin
        if (nfrm < 64) begin
            frm_cmd[nfrm] = cmd;
            frm_len[nfrm] = bidx;
        end
        nfrm++;
        if (cmd == 8'h05 && busy_left > 0) busy_left--;
    end

    // ---------------- monitors ----------------
    int  done_cnt = 0;
    int  sclk_viol = 0;
    int  hi_cnt = 0;
    int  min_gap = 1000000;
    bit  had_frame = 1'b0;

    always @(posedge clk) if (rst_n && done === 1'b1) done_cnt++;
    always @(negedge clk) if (rst_n && cs_n === 1'b1 && sclk !== 1'b0) sclk_viol++;
    always @(posedge clk) begin
        if (cs_n === 1'b1) hi_cnt++;
        else begin
            if (hi_cnt != 0 && had_frame && hi_cnt < min_gap) min_gap = hi_cnt;
            if (hi_cnt != 0) had_frame = 1'b1;
            hi_cnt = 0;
        end
    end

    task automatic clear_log();
        nfrm = 0; byte_err = 0; had_frame = 1'b0; min_gap = 1000000;
    endtask

    // Pulse start; optionally pulse again restart_at cycles later; wait for done.
    task automatic run_probe(input int restart_at, input string req);
        int k;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(probe_busy == 1'b1, "R11", {req, " busy after start"}, probe_busy, 1);
        k = 0;
        while (done !== 1'b1 && k < 20000) begin
            @(negedge clk);
            k++;
            start = (k == restart_at);
        end
        start = 1'b0;
        check(k < 20000, req, "probe finished", k, 0);
        check(probe_busy == 1'b0, "R11", {req, " busy low at done"}, probe_busy, 0);
    endtask

    task automatic check_frames(input int polls, input bit tail, input string req);
        int exp_n;
        exp_n = polls + (tail ? 2 : 0);
        check(nfrm == exp_n, req, "frame count", nfrm, exp_n);
        for (int i = 0; i < polls && i < nfrm; i++)
            check(frm_cmd[i] == 8'h05 && frm_len[i] == 2, "R3", "status frame", frm_cmd[i], 8'h05);
        if (tail && nfrm == exp_n) begin
            check(frm_cmd[polls] == 8'hFF && frm_len[polls] == 2, "R4", "mode reset frame",
                  frm_cmd[polls], 8'hFF);
            check(frm_cmd[polls+1] == 8'hAB && frm_len[polls+1] == 5, "R4", "wake frame",
                  frm_len[polls+1], 5);
        end
        check(byte_err == 0, "R2", "MSB-first bytes decoded", byte_err, 0);
    endtask

    task automatic check_result(input bit p, input bit t, input logic [7:0] id, input string req);
        check(present == p, req, "present", present, p);
        check(timeout == t, req, "timeout", timeout, t);
        check(dev_id == id, req, "dev_id", dev_id, id);
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int bad;
        bad = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cs_n !== 1'b1 || sclk !== 1'b0 || done !== 1'b0 || present !== 1'b0 ||
                timeout !== 1'b0 || dev_id !== 8'h00 || probe_busy !== 1'b0) bad++;
        end
        check(bad == 0, "R1", "idle outputs before start", bad, 0);
    endtask

    task automatic t_ready_device();
        miso_mode = 0; busy_left = 0; model_id = 8'h12; clear_log();
        run_probe(0, "R6");
        check_result(1'b1, 1'b0, 8'h12, "R6");
        check_frames(1, 1'b1, "R4");
        check(min_gap >= GAP_CYC, "R5", "min cs gap", min_gap, GAP_CYC);
    endtask

    task automatic t_busy_polls();
        miso_mode = 0; busy_left = 2; model_id = 8'h12; clear_log();
        run_probe(0, "R3");
        check_result(1'b1, 1'b0, 8'h12, "R3");
        check_frames(3, 1'b1, "R3");
        check(min_gap >= GAP_CYC, "R5", "min cs gap polls", min_gap, GAP_CYC);
    endtask

    task automatic t_limit_edge();
        miso_mode = 0; busy_left = POLL_LIMIT - 1; model_id = 8'h12; clear_log();
        run_probe(0, "R8");
        check_result(1'b1, 1'b0, 8'h12, "R8");
        check_frames(POLL_LIMIT, 1'b1, "R8");
    endtask

    task automatic t_limit_abort();
        miso_mode = 0; busy_left = POLL_LIMIT; model_id = 8'h12; clear_log();
        run_probe(0, "R8");
        check_result(1'b0, 1'b1, 8'h00, "R8");
        check_frames(POLL_LIMIT, 1'b0, "R8");
        busy_left = 0;
    endtask

    task automatic t_stuck_high();
        miso_mode = 2; clear_log();
        run_probe(0, "R8");
        check_result(1'b0, 1'b1, 8'h00, "R8");
        check_frames(POLL_LIMIT, 1'b0, "R8");
    endtask

    task automatic t_absent();
        miso_mode = 1; clear_log();
        run_probe(0, "R7");
        check_result(1'b0, 1'b0, 8'h00, "R7");
        check_frames(1, 1'b1, "R7");
    endtask

    task automatic t_wrong_id();
        miso_mode = 0; busy_left = 0; model_id = 8'h13; clear_log();
        run_probe(0, "R6");
        check_result(1'b0, 1'b0, 8'h13, "R6");
        model_id = 8'h12;
    endtask

    task automatic t_hold_and_clear();
        miso_mode = 0; busy_left = 0; model_id = 8'h12; clear_log();
        run_probe(0, "R9");
        repeat (100) @(negedge clk);
        check(present == 1'b1 && dev_id == 8'h12, "R9", "result held", dev_id, 8'h12);
        miso_mode = 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(present == 1'b0 && dev_id == 8'h00, "R9", "cleared by start", dev_id, 0);
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_restart_ignored();
        int d0;
        miso_mode = 0; busy_left = 1; model_id = 8'h12; clear_log();
        d0 = done_cnt;
        run_probe(40, "R10");
        check_result(1'b1, 1'b0, 8'h12, "R10");
        repeat (200) @(negedge clk);
        check(done_cnt - d0 == 1, "R10", "single done", done_cnt - d0, 1);
        check_frames(2, 1'b1, "R10");
    endtask

    initial begin
        t_reset();
        t_ready_device();
        t_busy_polls();
        t_limit_edge();
        t_limit_abort();
        t_stuck_high();
        t_absent();
        t_wrong_id();
        t_hold_and_clear();
        t_restart_ignored();
        check(sclk_viol == 0, "R2", "sclk low while deselected", sclk_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule